// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit up-counter that a processor core can read and write over a small register bus. The counter advances on one of two sources. The first is an internal instruction-cycle tick, which is one pulse every fourth system clock. The second is a chosen edge, rising or falling, of an external input. The external input first passes through a two-flop synchronizer. An 8-bit prescaler sits in front of the counter and divides the source by a power of two from 2 to 256. The prescaler can instead be handed to a watchdog path. In that case the counter sees the undivided source and the prescaler divides the watchdog's base pulse.

When the counter wraps from FFh to 00h, it sets a sticky overflow flag. Software clears this flag by writing a zero to it. The interrupt request is the flag gated by an enable bit. Writing the count register reloads the counter, clears the prescaler and swallows the next two instruction-cycle ticks' worth of increments. A sleep input freezes the counter, so no overflow can occur while it is asserted.

Register map (`bus_addr_i`): 0 = count; 1 = configuration, with bit 0 as the source select, bit 1 as the edge select, bit 2 as the prescaler-to-watchdog bit and bits 5:3 as the ratio code; 2 = control, with bit 0 as the overflow flag and bit 1 as the interrupt enable; 3 reads zero.

Top module: `presc_timer8`

## Requirements
- R1: After reset, the count, configuration and control registers read 00h and `irq_o` is low.
- R2: With configuration bit 0 clear, the counter advances once every instruction cycle, which is one step every 4 clocks.
- R3: A write to the count register loads the written value. The next 2 instruction-cycle ticks then produce no increment, so with no prescaler the first increment lands on the 11th clock edge after the write edge, when the write is made at instruction-cycle phase 0.
- R4: With configuration bit 0 set, the counter advances on external edges. Configuration bit 1 clear selects rising edges and bit 1 set selects falling edges. Edges of the other polarity have no effect.
- R5: An external edge changes the count on the third clock edge after the pin changes (two synchronizer stages plus the edge register).
- R6: With configuration bit 2 clear, the counter advances once per 2^(r+1) source pulses, where r is configuration bits 5:3. A count write or a configuration write restarts the prescaler.
- R7: With configuration bit 2 set, the counter takes the undivided source and `wdt_tick_o` pulses on every 2^(r+1)-th `wdt_base_i` pulse. With bit 2 clear, `wdt_tick_o` follows `wdt_base_i`.
- R8: A wrap from FFh to 00h sets control bit 0. The flag stays set until a control write with bit 0 = 0 clears it, and writing 1 to bit 0 never sets it.
- R9: If a flag-clearing control write and a wrap fall in the same cycle, the flag ends up set.
- R10: `irq_o` is high exactly when the flag and control bit 1 are both set.
- R11: While `sleep_i` is high, the count does not change except by a bus write, and the flag cannot be set.
- R12: Reads are combinational. The configuration register reads back what was written in bits 5:0, and address 3 reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Halts counting while high |
| ext_clk_i | input | 1 | External count input, asynchronous |
| wdt_base_i | input | 1 | Watchdog time-base pulse |
| bus_addr_i | input | 2 | Register select |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Overflow interrupt request |
| wdt_tick_o | output | 1 | Pulse forwarded to the watchdog path |

## Verification
The timer mode is driven from a table of load-value and wait-length pairs, all started from a known instruction-cycle phase. Wait lengths that straddle a boundary by one clock (10 against 11 after a write, 14 against 15 at ratio 1:4) separate a correct inhibit window and divide ratio from windows that are off by one. External input tests toggle the pin one level at a time, so that a rising edge, a falling edge and the synchronizer latency can each be seen alone in the count. Further directed tests place a flag clear on the very cycle of a wrap, count watchdog pulses in both prescaler assignments, and hold sleep across a span that would otherwise have advanced the counter.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_CFG   = 2'd1,
    REG_CTRL  = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  // Configuration register layout, LSB first: source, edge, prescaler owner, ratio code
  typedef struct packed {
    logic [2:0] ratio;
    logic       psc_wdt;
    logic       edge_fall;
    logic       src_ext;
  } cfg_t;

endpackage

// File: rtl/ptmr_sync_edge.sv
module ptmr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  assign sync_d[0] = pin_i;
  for (genvar gi = 1; gi < STAGES; gi++) begin : g_chain
    assign sync_d[gi] = sync_q[gi-1];
  end

  always_comb begin
    last_d = sync_q[STAGES-1];
    if (fall_sel_i) edge_o = ~sync_q[STAGES-1] & last_q;
    else            edge_o = sync_q[STAGES-1] & ~last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int unsigned PSC_W = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             in_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             out_o
);

  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] cnt_d;
  logic [PSC_W-1:0] low_mask;
  logic [SEL_W:0]   shamt;
  logic             hit;

  always_comb begin
    shamt = {1'b0, sel_i} + (SEL_W+1)'(1);
    for (int i = 0; i < PSC_W; i++) begin
      low_mask[i] = (32'(i) < 32'(shamt));
    end
    hit   = (cnt_q & low_mask) == low_mask;
    out_o = in_i & hit;
    if (clr_i)     cnt_d = '0;
    else if (in_i) cnt_d = cnt_q + PSC_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ptmr_count_core.sv
module ptmr_count_core #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned INH_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             inc_i,
  input  logic             icyc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             inhibit_o,
  output logic             wrap_o
);

  localparam int unsigned INH_W = $clog2(INH_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [INH_W-1:0] inh_q;
  logic [INH_W-1:0] inh_d;
  logic             step;

  always_comb begin
    inhibit_o = (inh_q != '0);
    step      = inc_i & ~inhibit_o & ~load_i;
    wrap_o    = step & (cnt_q == '1);

    if (load_i)                  inh_d = INH_W'(INH_TICKS);
    else if (inhibit_o && icyc_i) inh_d = inh_q - INH_W'(1);
    else                         inh_d = inh_q;

    if (load_i)    cnt_d = load_val_i;
    else if (step) cnt_d = cnt_q + CNT_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      inh_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      inh_q <= inh_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/presc_timer8.sv
module presc_timer8
  import ptmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PSC_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CYC_DIV     = 4,
  parameter int unsigned INH_TICKS   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_i,
  input  logic             ext_clk_i,
  input  logic             wdt_base_i,
  input  logic [1:0]       bus_addr_i,
  input  logic             bus_we_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  output logic             irq_o,
  output logic             wdt_tick_o
);

  localparam int unsigned CFG_W = $bits(cfg_t);
  localparam int unsigned CYC_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;

  reg_sel_e         sel;
  cfg_t             cfg_q, cfg_d;
  logic             flag_q, flag_d;
  logic             irq_en_q, irq_en_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_count, wr_cfg, wr_ctrl;
  logic             icyc_tick, ext_edge, src_pulse;
  logic             psc_in, psc_out, psc_clr;
  logic             cnt_inc, inh_active, wrap;

  assign sel = reg_sel_e'(bus_addr_i);

  // Write decode and instruction-cycle divider
  always_comb begin
    wr_count  = bus_we_i && (sel == REG_COUNT);
    wr_cfg    = bus_we_i && (sel == REG_CFG);
    wr_ctrl   = bus_we_i && (sel == REG_CTRL);
    icyc_tick = (cyc_q == CYC_W'(CYC_DIV - 1));
    cyc_d     = icyc_tick ? '0 : cyc_q + CYC_W'(1);
  end

  ptmr_sync_edge #(
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (ext_clk_i),
    .fall_sel_i (cfg_q.edge_fall),
    .edge_o     (ext_edge)
  );

  // Source selection and prescaler steering
  always_comb begin
    src_pulse  = ~sleep_i & (cfg_q.src_ext ? ext_edge : icyc_tick);
    psc_in     = cfg_q.psc_wdt ? wdt_base_i : src_pulse;
    psc_clr    = wr_cfg | (wr_count & ~cfg_q.psc_wdt);
    cnt_inc    = cfg_q.psc_wdt ? src_pulse : psc_out;
    wdt_tick_o = cfg_q.psc_wdt ? psc_out : wdt_base_i;
  end

  ptmr_prescaler #(
    .PSC_W (PSC_W),
    .SEL_W (3)
  ) psc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (psc_clr),
    .in_i  (psc_in),
    .sel_i (cfg_q.ratio),
    .out_o (psc_out)
  );

  ptmr_count_core #(
    .CNT_W     (CNT_W),
    .INH_TICKS (INH_TICKS)
  ) core_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (wr_count),
    .load_val_i (bus_wdata_i),
    .inc_i      (cnt_inc),
    .icyc_i     (icyc_tick),
    .cnt_o      (cnt_q),
    .inhibit_o  (inh_active),
    .wrap_o     (wrap)
  );

  // Register next state: a wrap outranks a software clear
  always_comb begin
    cfg_d    = wr_cfg ? cfg_t'(bus_wdata_i[CFG_W-1:0]) : cfg_q;
    irq_en_d = wr_ctrl ? bus_wdata_i[1] : irq_en_q;
    if (wrap)                          flag_d = 1'b1;
    else if (wr_ctrl && !bus_wdata_i[0]) flag_d = 1'b0;
    else                               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      flag_q   <= 1'b0;
      irq_en_q <= 1'b0;
      cyc_q    <= '0;
    end else begin
      cfg_q    <= cfg_d;
      flag_q   <= flag_d;
      irq_en_q <= irq_en_d;
      cyc_q    <= cyc_d;
    end
  end

  // Read mux and interrupt output
  always_comb begin
    unique case (sel)
      REG_COUNT: bus_rdata_o = cnt_q;
      REG_CFG:   bus_rdata_o = CNT_W'(cfg_q);
      REG_CTRL:  bus_rdata_o = CNT_W'({irq_en_q, flag_q});
      default:   bus_rdata_o = '0;
    endcase
    irq_o = flag_q & irq_en_q;
  end

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_i,
  input logic             wr_count,
  input logic             wr_ctrl,
  input logic [CNT_W-1:0] bus_wdata_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic             flag_q,
  input logic             irq_en_q,
  input logic             inh_active,
  input logic             irq_o,
  input logic             wdt_base_i,
  input logic             wdt_tick_o
);

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (cnt_q == $past(bus_wdata_i))); // R3

  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_active && !wr_count) |=> $stable(cnt_q)); // R3

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && !wr_count) |=> $stable(cnt_q)); // R11

  AST_SLEEP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && !flag_q) |=> !flag_q); // R11

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_ctrl && !bus_wdata_i[0])) |=> flag_q); // R8

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == '1 && cnt_q == '0 && !$past(wr_count)) |-> flag_q); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_q |-> !irq_o); // R10

  AST_WDT_ON_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tick_o |-> wdt_base_i); // R7

endmodule

bind presc_timer8 ptmr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_i     (sleep_i),
  .wr_count    (wr_count),
  .wr_ctrl     (wr_ctrl),
  .bus_wdata_i (bus_wdata_i),
  .cnt_q       (cnt_q),
  .flag_q      (flag_q),
  .irq_en_q    (irq_en_q),
  .inh_active  (inh_active),
  .irq_o       (irq_o),
  .wdt_base_i  (wdt_base_i),
  .wdt_tick_o  (wdt_tick_o)
);

// File: tb/presc_timer8_tb_top.sv
`timescale 1ns/1ps
module presc_timer8_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_i = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       wdt_base_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic       bus_we_i = 1'b0;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic       irq_o;
  logic       wdt_tick_o;

  int checks = 0;
  int fails = 0;
  int ecnt;

  always #2 clk = ~clk;

  presc_timer8 dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .ext_clk_i   (ext_clk_i),
    .wdt_base_i  (wdt_base_i),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .wdt_tick_o  (wdt_tick_o)
  );

  // Edge count since reset release, used to start writes at instruction phase 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  // {cfg, load, wait clocks, expected count, expected flag}
  localparam logic [40:0] VEC [0:7] = '{
    {8'h04, 8'h10, 16'd10,   8'h10, 1'b0},  // R3 still inhibited
    {8'h04, 8'h10, 16'd11,   8'h11, 1'b0},  // R3 first increment
    {8'h04, 8'h10, 16'd23,   8'h14, 1'b0},  // R2 one step per 4 clocks
    {8'h04, 8'hFE, 16'd15,   8'h00, 1'b1},  // R8 wrap sets flag
    {8'h08, 8'h20, 16'd14,   8'h20, 1'b0},  // R6 1:4 not yet
    {8'h08, 8'h20, 16'd15,   8'h21, 1'b0},  // R6 1:4 reached
    {8'h10, 8'h7F, 16'd31,   8'h80, 1'b0},  // R6 1:8
    {8'h38, 8'hFF, 16'd1023, 8'h00, 1'b1}   // R6 1:256 with wrap
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr_i  = a;
    bus_wdata_i = d;
    bus_we_i    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we_i    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  task automatic align_phase();
    while (ecnt % 4 != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int ticks;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 count", v, 8'h00);
    rd(2'd1, v); chk("R1 cfg", v, 8'h00);
    rd(2'd2, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // Table-driven timer-mode vectors
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, VEC[i][40:33]);
      wr(2'd2, 8'h00);
      align_phase();
      wr(2'd0, VEC[i][32:25]);
      repeat (int'(VEC[i][24:9])) @(negedge clk);
      rd(2'd0, v); chk($sformatf("R2/R3/R6 vec%0d count", i), v, VEC[i][8:1]);
      rd(2'd2, v); chk($sformatf("R8 vec%0d flag", i), {7'd0, v[0]}, {7'd0, VEC[i][0]});
    end

    // R12 readback
    wr(2'd1, 8'h2D);
    rd(2'd1, v); chk("R12 cfg readback", v, 8'h2D);
    rd(2'd3, v); chk("R12 unused address", v, 8'h00);

    // R9 clear and wrap in the same cycle
    wr(2'd1, 8'h04);
    wr(2'd2, 8'h00);
    align_phase();
    wr(2'd0, 8'hFF);
    repeat (10) @(negedge clk);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R9 flag survives clear", {7'd0, v[0]}, 8'h01);
    rd(2'd0, v); chk("R9 count wrapped", v, 8'h00);

    // R10 masking, R8 clear and no software set
    chk("R10 masked irq", {7'd0, irq_o}, 8'h00);
    wr(2'd2, 8'h03);
    chk("R10 enabled irq", {7'd0, irq_o}, 8'h01);
    wr(2'd2, 8'h02);
    rd(2'd2, v); chk("R8 flag cleared", v, 8'h02);
    chk("R10 irq after clear", {7'd0, irq_o}, 8'h00);
    wr(2'd2, 8'h03);
    rd(2'd2, v); chk("R8 write one does not set", {7'd0, v[0]}, 8'h00);
    wr(2'd2, 8'h00);

    // R11 sleep freezes the counter
    sleep_i = 1'b1;
    align_phase();
    wr(2'd0, 8'h40);
    repeat (20) @(negedge clk);
    rd(2'd0, v); chk("R11 frozen in sleep", v, 8'h40);
    sleep_i = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R11 resumes after sleep", v, 8'h41);

    // R4/R5 external edges, prescaler on watchdog (cfg 05h rising, 07h falling)
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h00);
    repeat (12) @(negedge clk);
    ext_clk_i = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd0, v); chk("R5 no change after two edges", v, 8'h00);
    @(negedge clk);
    rd(2'd0, v); chk("R5 counted on third edge", v, 8'h01);
    ext_clk_i = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd0, v); chk("R4 falling ignored in rising mode", v, 8'h01);
    wr(2'd1, 8'h07);
    ext_clk_i = 1'b1;
    repeat (6) @(negedge clk);
    rd(2'd0, v); chk("R4 rising ignored in falling mode", v, 8'h01);
    ext_clk_i = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd0, v); chk("R4 falling counted", v, 8'h02);
    wr(2'd1, 8'h05);
    for (int p = 0; p < 5; p++) begin
      ext_clk_i = 1'b1; repeat (3) @(negedge clk);
      ext_clk_i = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R4 burst of rising edges", v, 8'h07);

    // R7 watchdog path: cfg 0Ch divides base by 4, cfg 08h passes it through
    wr(2'd1, 8'h0C);
    ticks = 0;
    for (int p = 0; p < 8; p++) begin
      wdt_base_i = 1'b1;
      #1;
      if (wdt_tick_o) ticks++;
      if (p == 3) chk("R7 tick on fourth base pulse", {7'd0, wdt_tick_o}, 8'h01);
      @(negedge clk);
      wdt_base_i = 1'b0;
      @(negedge clk);
    end
    chk("R7 divided tick count", 8'(ticks), 8'd2);
    wr(2'd1, 8'h08);
    ticks = 0;
    for (int p = 0; p < 3; p++) begin
      wdt_base_i = 1'b1;
      #1;
      if (wdt_tick_o) ticks++;
      @(negedge clk);
      wdt_base_i = 1'b0;
      @(negedge clk);
    end
    chk("R7 passthrough tick count", 8'(ticks), 8'd3);

    finish_run();
  end

endmodule